// File: doc/BRIEF.md
# Self-Calibrating Periodic Interval Timer

This block is a down-counting interrupt timer that works out its own reload value. An external reference source supplies a tick at the wanted interrupt rate. On a calibration request the block loads its counter with all ones. The counter then counts down once per prescaled clock, where the prescaler divides the core clock by `PRESCALE`. The counter value at the first reference tick becomes a baseline. A window of `WINDOW` further reference ticks then follows. After that window the block divides the prescaled ticks that elapsed by the window length, which gives the number of prescaled ticks in one reference period.

When calibration ends, the counter is parked at zero for one cycle. It is then loaded with the computed value and the block enters its run phase. A configuration word selects the behaviour of the run phase:
- **Periodic**: the counter reloads itself after each terminal count and raises an interrupt every time it reaches zero.
- **One-shot**: the counter stops at zero after a single interrupt.
- **Deadline**: a free-running timestamp is compared with a programmed deadline. This mode does not use the counter and does not need calibration. On each hit the deadline moves forward by `TS_HZ / TICK_HZ` timestamp counts.

Every interrupt is a single-cycle pulse and comes with the vector number from the configuration word.

Top module: `selfcal_timer`

## Requirements
- R1: After reset the counter, the reload value, the calibrated flag and the interrupt are all zero. The configuration word resets to 32, which is vector 32 with no mode bit set.
- R2: A pulse on `start_cal` loads the counter with all ones in the next cycle and clears `calibrated`. During calibration the counter then decreases by one at every `PRESCALE`-th clock.
- R3: At the first `ref_tick` of calibration the block records baseline = all-ones minus the count. At the (WINDOW+1)-th `ref_tick` the block stores reload = (all-ones minus the count, minus baseline) divided by WINDOW, rounded down. Both counts are taken before that clock edge.
- R4: On the edge that ends calibration the counter becomes 0 and stays 0 for exactly one cycle. On the next edge the counter takes the reload value and `calibrated` rises.
- R5: In periodic mode (config bit 17 set, bit 18 clear), the counter decreases once per prescaled tick. `irq` pulses for one cycle in the cycle where the counter first reads 0. The reload value is restored on the following prescaled tick, so interrupts repeat every (reload+1)·PRESCALE clocks.
- R6: With config bits 17 and 18 both clear, the counter stops at 0 after raising a single interrupt.
- R7: During every `irq` pulse, `irq_vec` equals config bits 7:0 as they were in the cycle before the pulse.
- R8: Config bit 18 selects deadline mode and takes priority over bit 17. One cycle after the bit is set, the deadline is armed at `tstamp` + STEP, where STEP = TS_HZ/TICK_HZ. `irq` pulses when `tstamp` reaches the deadline, and the deadline then re-arms at that timestamp + STEP. The counter holds its value in this mode. `tstamp` advances by one every clock.
- R9: `ref_tick` has no effect outside calibration.
- R10: `start_cal` while the block is running restarts calibration from all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_cal | input | 1 | One-cycle request to begin calibration |
| ref_tick | input | 1 | One-cycle reference tick at the target interrupt rate |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word: [7:0] vector, [17] periodic, [18] deadline |
| irq | output | 1 | Single-cycle interrupt pulse |
| irq_vec | output | 8 | Vector number that goes with the interrupt |
| cur_count | output | CNT_W | Present counter value |
| reload_val | output | CNT_W | Calibrated reload value |
| calibrated | output | 1 | High once the calibrated value has been loaded |
| tstamp | output | TS_W | Free-running timestamp |

## Verification
Some properties are checked by assertions on every cycle:
- during calibration the counter never falls by more than one per cycle;
- the counter never rises above the reload value while running;
- `calibrated` only rises after a cycle with the counter at zero;
- a counter at one on a prescaled tick always produces a zero count with an interrupt;
- the vector always matches the previous configuration;
- an armed deadline always lies within one step ahead of the timestamp.

The bench scenarios are what demonstrate the remaining behaviour. It sweeps the reference period to show that the reload arithmetic and baseline handling give the right value. It shows the exact cycles of periodic and one-shot interrupts, and the count of deadline hits over a window. It also shows that reference ticks outside calibration leave the state untouched.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAL  = 2'd1,
    ST_STOP = 2'd2,
    ST_RUN  = 2'd3
  } ctmr_state_e;

  localparam int          CFG_PERIODIC_BIT = 17;
  localparam int          CFG_DEADLINE_BIT = 18;
  localparam logic [31:0] CFG_RESET        = 32'd32;
endpackage

// File: rtl/ctmr_prescale.sv
module ctmr_prescale #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = pc_q;
    if (clr)
      pc_d = '0;
    else if (en)
      pc_d = (pc_q == LAST) ? '0 : pc_q + 1'b1;
  end

  assign tick = en && !clr && (pc_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/ctmr_calib.sv
module ctmr_calib #(
  parameter int CNT_W  = 32,
  parameter int WINDOW = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             active,
  input  logic             ref_tick,
  input  logic [CNT_W-1:0] cnt,
  output logic             done,
  output logic [CNT_W-1:0] reload
);
  localparam int SW = $clog2(WINDOW + 1);
  localparam logic [SW-1:0]    WIN_S = SW'(WINDOW);
  localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WINDOW);

  logic [SW-1:0]    seen_q, seen_d;
  logic [CNT_W-1:0] base_q, base_d;
  logic [CNT_W-1:0] elapsed, span;

  // all-ones minus the count is the bitwise complement
  assign elapsed = ~cnt;
  assign span    = elapsed - base_q;
  assign reload  = span / WIN_C;
  assign done    = active && ref_tick && (seen_q == WIN_S);

  always_comb begin
    seen_d = seen_q;
    base_d = base_q;
    if (clr) begin
      seen_d = '0;
      base_d = '0;
    end else if (active && ref_tick && !done) begin
      seen_d = seen_q + 1'b1;
      if (seen_q == '0) base_d = elapsed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      base_q <= '0;
    end else begin
      seen_q <= seen_d;
      base_q <= base_d;
    end
  end

  // R3
  seen_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q <= WIN_S);
endmodule

// File: rtl/ctmr_deadline.sv
module ctmr_deadline #(
  parameter int              TS_W = 64,
  parameter longint unsigned STEP = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  output logic [TS_W-1:0] ts,
  output logic            fire
);
  localparam logic [TS_W-1:0] STEP_W = TS_W'(STEP);

  logic [TS_W-1:0] ts_q, ts_d, dl_q, dl_d;
  logic            armed_q, armed_d;

  assign fire = en && armed_q && (ts_q >= dl_q);
  assign ts   = ts_q;

  always_comb begin
    ts_d    = ts_q + 1'b1;
    dl_d    = dl_q;
    armed_d = armed_q;
    if (!en) begin
      armed_d = 1'b0;
    end else if (!armed_q) begin
      armed_d = 1'b1;
      dl_d    = ts_q + STEP_W;
    end else if (fire) begin
      dl_d    = ts_q + STEP_W;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q    <= '0;
      dl_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      ts_q    <= ts_d;
      dl_q    <= dl_d;
      armed_q <= armed_d;
    end
  end

  // R8
  dl_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && en) |-> ((dl_q >= ts_q) && ((dl_q - ts_q) <= STEP_W)));
endmodule

// File: rtl/selfcal_timer.sv
module selfcal_timer
  import ctmr_pkg::*;
#(
  parameter int              CNT_W    = 32,
  parameter int              PRESCALE = 64,
  parameter int              WINDOW   = 100,
  parameter int              TS_W     = 64,
  parameter longint unsigned TS_HZ    = 64'd1_000_000_000,
  parameter longint unsigned TICK_HZ  = 64'd1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_cal,
  input  logic             ref_tick,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  output logic             irq,
  output logic [7:0]       irq_vec,
  output logic [CNT_W-1:0] cur_count,
  output logic [CNT_W-1:0] reload_val,
  output logic             calibrated,
  output logic [TS_W-1:0]  tstamp
);
  localparam longint unsigned DL_STEP = TS_HZ / TICK_HZ;

  logic [1:0]       rst_s;
  logic             rst_i;
  ctmr_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, rel_q, rel_d, cal_reload;
  logic [31:0]      cfg_q, cfg_d;
  logic             calib_q, calib_d, irq_q, irq_d, cnt_irq;
  logic [7:0]       vec_q, vec_d;
  logic             dl_mode, per_mode, pre_en, pre_clr, pre_tick;
  logic             cal_active, cal_done, dl_fire;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_s <= 2'b00;
    else        rst_s <= {rst_s[0], 1'b1};
  end
  assign rst_i = rst_s[1];

  assign dl_mode    = cfg_q[CFG_DEADLINE_BIT];
  assign per_mode   = cfg_q[CFG_PERIODIC_BIT];
  assign pre_en     = (st_q == ST_CAL) || ((st_q == ST_RUN) && !dl_mode);
  assign pre_clr    = start_cal || (st_q == ST_STOP);
  assign cal_active = (st_q == ST_CAL) && !start_cal;

  ctmr_prescale #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_i), .clr(pre_clr), .en(pre_en), .tick(pre_tick)
  );

  ctmr_calib #(.CNT_W(CNT_W), .WINDOW(WINDOW)) u_cal (
    .clk(clk), .rst_n(rst_i), .clr(start_cal), .active(cal_active),
    .ref_tick(ref_tick), .cnt(cnt_q), .done(cal_done), .reload(cal_reload)
  );

  ctmr_deadline #(.TS_W(TS_W), .STEP(DL_STEP)) u_dl (
    .clk(clk), .rst_n(rst_i), .en(dl_mode), .ts(tstamp), .fire(dl_fire)
  );

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    rel_d   = rel_q;
    calib_d = calib_q;
    cnt_irq = 1'b0;
    cfg_d   = cfg_we ? cfg_wdata : cfg_q;
    if (start_cal) begin
      st_d    = ST_CAL;
      cnt_d   = '1;
      calib_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_CAL: begin
          if (cal_done) begin
            st_d  = ST_STOP;
            cnt_d = '0;
            rel_d = cal_reload;
          end else if (pre_tick) begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_STOP: begin
          st_d    = ST_RUN;
          cnt_d   = rel_q;
          calib_d = 1'b1;
        end
        ST_RUN: begin
          if (pre_tick) begin
            if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
            else if (per_mode) cnt_d = rel_q;
            cnt_irq = (cnt_q == CNT_W'(1));
          end
        end
        default: ;
      endcase
    end
    irq_d = cnt_irq || dl_fire;
    vec_d = irq_d ? cfg_q[7:0] : vec_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      rel_q   <= '0;
      calib_q <= 1'b0;
      irq_q   <= 1'b0;
      vec_q   <= '0;
      cfg_q   <= CFG_RESET;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      rel_q   <= rel_d;
      calib_q <= calib_d;
      irq_q   <= irq_d;
      vec_q   <= vec_d;
      cfg_q   <= cfg_d;
    end
  end

  assign irq        = irq_q;
  assign irq_vec    = vec_q;
  assign cur_count  = cnt_q;
  assign reload_val = rel_q;
  assign calibrated = calib_q;

  // R2
  cal_dec_chk: assert property (@(posedge clk) disable iff (!rst_i)
    ((st_q == ST_CAL) && ($past(st_q) == ST_CAL) && !$past(start_cal))
      |-> (($past(cnt_q) - cnt_q) <= CNT_W'(1)));
  // R4
  cal_load_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(calib_q) |-> (($past(cnt_q) == '0) && (cnt_q == rel_q)));
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == ST_RUN) |-> (cnt_q <= rel_q));
  // R5
  cnt_zero_irq_chk: assert property (@(posedge clk) disable iff (!rst_i)
    ((st_q == ST_RUN) && pre_tick && (cnt_q == CNT_W'(1)) && !start_cal)
      |=> (irq_q && (cnt_q == '0)));
  // R7
  vec_match_chk: assert property (@(posedge clk) disable iff (!rst_i)
    irq_q |-> (vec_q == $past(cfg_q[7:0])));
endmodule

// File: tb/tb_selfcal_timer.sv
`timescale 1ns/1ps
module tb_selfcal_timer;
  localparam int          P    = 4;
  localparam int          W    = 4;
  localparam int          STEP = 20;
  localparam logic [31:0] ALL1 = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n, start_cal, ref_tick, cfg_we;
  logic [31:0] cfg_wdata;
  logic        irq, calibrated;
  logic [7:0]  irq_vec;
  logic [31:0] cur_count, reload_val;
  logic [63:0] tstamp;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  selfcal_timer #(
    .CNT_W(32), .PRESCALE(P), .WINDOW(W), .TS_W(64),
    .TS_HZ(64'd20000), .TICK_HZ(64'd1000)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_cal(start_cal), .ref_tick(ref_tick),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .irq(irq), .irq_vec(irq_vec),
    .cur_count(cur_count), .reload_val(reload_val), .calibrated(calibrated),
    .tstamp(tstamp)
  );

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic calibrate(input int r, output int rel);
    int n_all;
    start_cal = 1'b1;
    @(negedge clk);
    start_cal = 1'b0;
    chk("R2 R10 count loaded all ones", cur_count, ALL1);
    chk("R2 R10 calibrated cleared", calibrated, 0);
    n_all = r * (W + 1);
    for (int n = 1; n <= n_all; n++) begin
      ref_tick = (n % r == 0);
      @(negedge clk);
      if (n == r) chk("R2 countdown per prescaled tick", cur_count, ALL1 - n / P);
    end
    ref_tick = 1'b0;
    chk("R4 counter parked at zero", cur_count, 0);
    chk("R4 not yet calibrated", calibrated, 0);
    rel = ((n_all - 1) / P - (r - 1) / P) / W;
    @(negedge clk);
    chk("R3 reload value", reload_val, rel);
    chk("R4 counter loaded", cur_count, rel);
    chk("R4 calibrated set", calibrated, 1);
  endtask

  task automatic watch_counter(input int rel, input bit periodic, input logic [7:0] vec, input int kmax);
    int seen = 0;
    int expn;
    bit ok;
    for (int k = 1; k <= kmax; k++) begin
      @(negedge clk);
      if (irq) begin
        seen++;
        ok = periodic ? (k >= rel * P && ((k - rel * P) % ((rel + 1) * P)) == 0)
                      : (k == rel * P);
        chk(periodic ? "R5 periodic irq timing" : "R6 one-shot irq timing", ok, 1);
        chk("R7 vector during irq", irq_vec, vec);
      end
    end
    if (periodic) expn = (kmax >= rel * P) ? (kmax - rel * P) / ((rel + 1) * P) + 1 : 0;
    else          expn = (kmax >= rel * P) ? 1 : 0;
    chk(periodic ? "R5 periodic irq count" : "R6 one-shot irq count", seen, expn);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int rel;
    int rlist [8] = '{5, 6, 7, 9, 11, 13, 16, 21};
    logic [31:0] c0;
    logic [63:0] t0;
    int dseen;
    rst_n = 1'b0; start_cal = 1'b0; ref_tick = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 count", cur_count, 0);
    chk("R1 reload", reload_val, 0);
    chk("R1 calibrated", calibrated, 0);
    chk("R1 irq", irq, 0);

    // R9 reference tick while idle
    ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0; @(negedge clk);
    chk("R9 idle ref_tick reload", reload_val, 0);
    chk("R9 idle ref_tick count", cur_count, 0);

    // R6 one-shot with reset configuration, R1 default vector 32
    calibrate(12, rel);
    watch_counter(rel, 1'b0, 8'd32, rel * P + 3 * (rel + 1) * P);
    chk("R6 counter stays at zero", cur_count, 0);

    // R5 periodic sweep over reference periods
    foreach (rlist[i]) begin
      write_cfg((32'd1 << 17) | (32'h40 + 32'(i)));
      calibrate(rlist[i], rel);
      watch_counter(rel, 1'b1, 8'(8'h40 + i), rel * P + 3 * (rel + 1) * P);
    end

    // R9 reference tick while running
    c0 = reload_val;
    ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0; @(negedge clk);
    chk("R9 run ref_tick reload", reload_val, c0);
    chk("R9 run ref_tick calibrated", calibrated, 1);

    // R8 deadline mode, priority over periodic bit
    write_cfg((32'd1 << 18) | (32'd1 << 17) | 32'h5C);
    c0 = cur_count;
    t0 = tstamp;
    dseen = 0;
    for (int i = 1; i <= 5 * STEP + 1; i++) begin
      @(negedge clk);
      if (i == 1) chk("R8 timestamp advances", tstamp, t0 + 1);
      if (irq) begin
        dseen++;
        chk("R8 deadline hit timing",
            (tstamp > t0 + 1) && (((tstamp - t0 - 1) % STEP) == 0), 1);
        chk("R7 deadline vector", irq_vec, 8'h5C);
      end
    end
    chk("R8 deadline hit count", dseen, 5);
    chk("R8 counter held", cur_count, c0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule